// File: doc/BRIEF.md
# Coprocessor-Port Accelerator Wrapper

This block hangs off the coprocessor register-transfer port of a CPU core. The core moves one 32-bit word at a time to or from a 4-bit coprocessor register number, and the wrapper turns those numbers into a small register file in front of a generic accelerator. The register file holds a bank of input buffers that feed the accelerator, a bank of output buffers that capture its results, an options word, and a ready flag.

Register number 15 has two roles. A write to it loads the options word and launches the accelerator with a one-cycle start pulse. A read of it returns the ready flag, which software polls to learn that the work is done. Numbers 0 to 14 address input buffers on writes and output buffers on reads. A transfer only acts when the coprocessor number that comes with it matches the wrapper's configured number and the core stall input is low.

Top module: `copro_accel_wrap`

## Requirements
- R1: `cp_op` selects the transfer: 2 writes, 1 reads, and 0 or 3 change no state. `cp_rdata` is zero in every cycle that is not an accepted read.
- R2: A write to register k, with k below NUM_IN, stores `cp_wdata` into input buffer k at the next rising edge. Input buffer k drives bits [32k+31:32k] of `acc_in_flat`.
- R3: A write to a register number from NUM_IN to 14 is discarded and leaves every input buffer unchanged.
- R4: A write to register 15 loads `acc_opts` at the next edge. `acc_start` is high for exactly the one cycle after that edge.
- R5: A read of register 15 returns the ready flag in bit 0, with bits 31:1 zero. A write to register 15 clears the flag.
- R6: In a cycle with `acc_ready` high, output buffer k captures bits [32k+31:32k] of `acc_out_flat` and the ready flag is set. If a write to register 15 is accepted in the same cycle, the flag is cleared instead.
- R7: A read of register k below NUM_OUT returns output buffer k in the same cycle. A read of a number from NUM_OUT to 14 returns zero.
- R8: While `stall` is high, writes change nothing, no start pulse is produced, and reads return zero.
- R9: A transfer whose `cp_unit` differs from parameter UNIT_ID (default 5) is ignored in the same way as a stalled one.
- R10: Synchronous reset clears the input and output buffers, `acc_opts`, `acc_start` and the ready flag. Reset takes effect even while `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Core stall; blocks all transfers |
| cp_unit | input | 4 | Coprocessor number of the transfer |
| cp_reg | input | 4 | Coprocessor register number |
| cp_op | input | 2 | Transfer code: 0 idle, 1 read, 2 write |
| cp_wdata | input | 32 | Write data from the core |
| cp_rdata | output | 32 | Read data to the core (combinational) |
| acc_start | output | 1 | One-cycle accelerator start pulse |
| acc_opts | output | 32 | Options word to the accelerator |
| acc_in_flat | output | NUM_IN*32 | Input buffers, buffer k at bits [32k+31:32k] |
| acc_ready | input | 1 | Accelerator completion strobe |
| acc_out_flat | input | NUM_OUT*32 | Accelerator results, result k at bits [32k+31:32k] |

## Verification
The bench targets the places where register decode goes wrong. It writes to numbers just above the input count and reads numbers above the output count. A decoder that wraps or truncates the index would corrupt a real buffer or return stale data. It also sends the unused codes 0 and 3 with live data, which a design that decodes only one bit of the code would treat as a write. It then forces a ready strobe into the same edge as a write to register 15. A design that gives ready priority would report the new job as already done. Finally it raises reset while stall is high, which catches a stall that also freezes reset.

// File: rtl/copro_accel_wrap.sv
module copro_accel_wrap #(
  parameter int NUM_IN = 2,
  parameter int NUM_OUT = 2,
  parameter logic [3:0] UNIT_ID = 4'd5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stall,
  input  logic [3:0]              cp_unit,
  input  logic [3:0]              cp_reg,
  input  logic [1:0]              cp_op,
  input  logic [31:0]             cp_wdata,
  output logic [31:0]             cp_rdata,
  output logic                    acc_start,
  output logic [31:0]             acc_opts,
  output logic [NUM_IN*32-1:0]    acc_in_flat,
  input  logic                    acc_ready,
  input  logic [NUM_OUT*32-1:0]   acc_out_flat
);
  localparam int W = 32;
  localparam logic [3:0] CTL_REG = 4'd15;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_WR = 2'd2;

  logic [NUM_IN-1:0][W-1:0]  in_buf;
  logic [NUM_OUT-1:0][W-1:0] out_buf;
  logic poll;
  logic [W-1:0] rd_val;

  wire accept = !stall && (cp_unit == UNIT_ID);
  wire wr     = accept && (cp_op == OP_WR);
  wire rd     = accept && (cp_op == OP_RD);
  wire wr_ctl = wr && (cp_reg == CTL_REG);

  assign acc_in_flat = in_buf;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    always_ff @(posedge clk)
      if (rst) in_buf[gi] <= '0;
      else if (wr && cp_reg == 4'(gi)) in_buf[gi] <= cp_wdata;
  end

  for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
    always_ff @(posedge clk)
      if (rst) out_buf[go] <= '0;
      else if (acc_ready) out_buf[go] <= acc_out_flat[go*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_opts  <= '0;
      acc_start <= 1'b0;
      poll      <= 1'b0;
    end else begin
      acc_start <= wr_ctl;
      if (wr_ctl) acc_opts <= cp_wdata;
      if (wr_ctl) poll <= 1'b0;
      else if (acc_ready) poll <= 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    if (cp_reg == CTL_REG) rd_val = {{(W-1){1'b0}}, poll};
    for (int k = 0; k < NUM_OUT; k++)
      if (cp_reg == 4'(k)) rd_val = out_buf[k];
  end

  assign cp_rdata = rd ? rd_val : '0;

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cp_op != OP_RD) |-> (cp_rdata == '0)); // R1
  AST_OPTS_WITH_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc_opts) |-> acc_start); // R4
  AST_START_CLEARS_POLL: assert property (@(posedge clk) disable iff (rst)
    acc_start |-> !poll); // R5
  AST_READY_SETS_POLL: assert property (@(posedge clk) disable iff (rst)
    (acc_ready && !wr_ctl) |=> poll); // R6
  AST_STALL_NO_START: assert property (@(posedge clk) disable iff (rst)
    stall |=> !acc_start); // R8
  AST_UNIT_NO_START: assert property (@(posedge clk) disable iff (rst)
    (cp_unit != UNIT_ID) |=> !acc_start); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!acc_start && !poll && acc_opts == '0)); // R10
endmodule

// File: tb/copro_accel_wrap_test.sv
module copro_accel_wrap_test;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam logic [3:0] UID = 4'd5;
  localparam int VW = 2 + 4 + 32 + 8 + 32;

  logic clk = 0, rst = 1, stall = 0;
  logic [3:0] cp_unit = UID, cp_reg = 0;
  logic [1:0] cp_op = 0;
  logic [31:0] cp_wdata = 0;
  logic [31:0] cp_rdata;
  logic acc_start;
  logic [31:0] acc_opts;
  logic [NI*32-1:0] acc_in_flat;
  logic acc_ready;
  logic [NO*32-1:0] acc_out_flat = '0;
  logic mready = 0, man_ready = 0;
  logic [3:0] cnt = 0;
  int checks = 0, errors = 0, start_cnt = 0;

  assign acc_ready = mready | man_ready;

  copro_accel_wrap #(.NUM_IN(NI), .NUM_OUT(NO), .UNIT_ID(UID)) uut (
    .clk(clk), .rst(rst), .stall(stall), .cp_unit(cp_unit), .cp_reg(cp_reg),
    .cp_op(cp_op), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .acc_start(acc_start), .acc_opts(acc_opts), .acc_in_flat(acc_in_flat),
    .acc_ready(acc_ready), .acc_out_flat(acc_out_flat));

  always #5 clk = ~clk;

  // accelerator model: out0 = in0 + in1 + opts, out1 = in0 ^ in1, ready 4 cycles after start
  always @(posedge clk) begin
    if (acc_start) start_cnt <= start_cnt + 1;
    if (rst) begin
      cnt <= 0; mready <= 0;
    end else begin
      mready <= (cnt == 1);
      if (cnt == 1)
        acc_out_flat <= {acc_in_flat[31:0] ^ acc_in_flat[63:32],
                         acc_in_flat[31:0] + acc_in_flat[63:32] + acc_opts};
      if (acc_start) cnt <= 3;
      else if (cnt != 0) cnt <= cnt - 1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    cp_op = op; cp_reg = r; cp_wdata = d;
    @(posedge clk); #1;
    cp_op = 0;
  endtask

  task automatic rd(input logic [3:0] r, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cp_op = 1; cp_reg = r;
    #1 check(tag, 64'(cp_rdata), 64'(exp));
    cp_op = 0;
  endtask

  // op, reg, data, idle cycles, expected read data
  localparam logic [VW-1:0] VEC [15] = '{
    {2'd2, 4'd0,  32'h5,    8'd0, 32'h0},    // R2
    {2'd2, 4'd1,  32'h7,    8'd0, 32'h0},    // R2
    {2'd2, 4'd2,  32'hDEAD, 8'd0, 32'h0},    // R3 discarded
    {2'd3, 4'd0,  32'hBAD,  8'd0, 32'h0},    // R1 code 3
    {2'd0, 4'd1,  32'hBAD,  8'd0, 32'h0},    // R1 idle
    {2'd1, 4'd0,  32'h0,    8'd0, 32'h0},    // R10 out buffer reset
    {2'd1, 4'd15, 32'h0,    8'd0, 32'h0},    // R5 poll after reset
    {2'd2, 4'd15, 32'h100,  8'd0, 32'h0},    // R4 start
    {2'd1, 4'd15, 32'h0,    8'd0, 32'h0},    // R5 cleared
    {2'd0, 4'd0,  32'h0,    8'd6, 32'h0},    // wait for model
    {2'd1, 4'd15, 32'h0,    8'd0, 32'h1},    // R6 poll set
    {2'd1, 4'd0,  32'h0,    8'd0, 32'h10C},  // R7
    {2'd1, 4'd1,  32'h0,    8'd0, 32'h2},    // R7
    {2'd1, 4'd5,  32'h0,    8'd0, 32'h0},    // R7 above NUM_OUT
    {2'd1, 4'd14, 32'h0,    8'd0, 32'h0}     // R7 above NUM_OUT
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset start", 64'(acc_start), 0);
    check("R10 reset opts", 64'(acc_opts), 0);
    @(negedge clk) rst = 0;

    for (int i = 0; i < 15; i++) begin
      logic [1:0] op; logic [3:0] r; logic [31:0] d, e; logic [7:0] w;
      {op, r, d, w, e} = VEC[i];
      if (op == 2'd1) rd(r, e, $sformatf("R7/R5/R6 vector %0d", i));
      else drive(op, r, d);
      repeat (w) @(posedge clk);
    end
    #1;
    check("R2 R3 R1 input buffers", 64'(acc_in_flat), {32'h7, 32'h5});
    check("R4 opts", 64'(acc_opts), 64'h100);
    check("R4 one start", 64'(start_cnt), 1);

    // R4: pulse in the cycle after the write edge only
    drive(2, 15, 32'h200);
    check("R4 start high", 64'(acc_start), 1);
    @(posedge clk); #1;
    check("R4 start low", 64'(acc_start), 0);
    repeat (6) @(posedge clk);
    rd(0, 32'h20C, "R6 capture new result");

    // R8 stall
    stall = 1;
    drive(2, 0, 32'h99);
    drive(2, 15, 32'h300);
    check("R8 stall no start", 64'(acc_start), 0);
    rd(0, 32'h0, "R8 stalled read");
    #1 check("R8 stall input buffers", 64'(acc_in_flat), {32'h7, 32'h5});
    check("R8 stall opts", 64'(acc_opts), 64'h200);
    stall = 0;

    // R9 wrong unit
    cp_unit = 4'd3;
    drive(2, 15, 32'h400);
    check("R9 no start", 64'(acc_start), 0);
    drive(2, 1, 32'h44);
    rd(0, 32'h0, "R9 foreign read");
    cp_unit = UID;
    #1 check("R9 opts kept", 64'(acc_opts), 64'h200);
    check("R9 inputs kept", 64'(acc_in_flat), {32'h7, 32'h5});
    check("R9 start count", 64'(start_cnt), 2);

    // R6 priority of start clear over ready
    @(negedge clk) man_ready = 1;
    @(posedge clk); #1 man_ready = 0;
    rd(15, 32'h1, "R6 manual ready sets poll");
    @(negedge clk);
    man_ready = 1; cp_op = 2; cp_reg = 15; cp_wdata = 32'h500;
    @(posedge clk); #1;
    man_ready = 0; cp_op = 0;
    rd(15, 32'h0, "R6 start clear wins");
    repeat (8) @(posedge clk);
    rd(15, 32'h1, "R6 later completion");
    rd(1, 32'h2, "R7 out1 after rerun");

    // R10 reset while stalled
    @(negedge clk); stall = 1; rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0; stall = 0;
    #1;
    check("R10 opts cleared", 64'(acc_opts), 0);
    check("R10 inputs cleared", 64'(acc_in_flat), 0);
    check("R10 start cleared", 64'(acc_start), 0);
    rd(15, 32'h0, "R10 poll cleared");
    rd(0, 32'h0, "R10 out buffer cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule